// File: doc/BRIEF.md
# Dual-Strobe Mode-Selected Shift Register

This block is a small parallel-access register with one serial input, a parallel data input, a mode input and two strobe inputs. The strobes are slow, level-style signals that live outside the system clock domain. Each strobe is synchronized into the system clock, and its high-to-low transitions are detected. A falling edge on the shift strobe moves the contents one place toward the top bit, and the serial bit enters bit 0. A falling edge on the load strobe copies the parallel inputs into the register. The mode level decides which of the two strobes may act.

There is no separate internal direction control. To move data from the top bit toward bit 0, the user puts the register in load mode and wires it back on itself:
- each parallel input `par_i[i]` is driven from `q_o[i+1]`;
- the new serial data is applied at `par_i[WIDTH-1]`.

When one clock source is enough, the two strobe inputs may be tied together. The mode level alone then chooses between shifting and loading.

Top module: `dual_strobe_shift_reg`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, `q_o` becomes all zeros and the edge-detector history is cleared. If either strobe is held high through the release of reset, `q_o` stays zero afterwards.
- R2: When `mode_load_i` is 1 and `strobe_ld_i` falls, `q_o[i]` takes `par_i[i]` for every bit i. Bit 0 is the stage nearest the serial entry.
- R3: During a parallel load, the value of `ser_i` has no effect on the result.
- R4: When `mode_load_i` is 0 and `strobe_sh_i` falls, `q_o[i]` takes the old `q_o[i-1]` for i ≥ 1, and `q_o[0]` takes `ser_i`.
- R5: A rising edge on either strobe never changes `q_o`, whatever the data inputs hold at that time.
- R6: These events leave `q_o` unchanged:
  - a falling edge on `strobe_sh_i` while `mode_load_i` is 1;
  - a falling edge on `strobe_ld_i` while `mode_load_i` is 0;
  - any change of `mode_load_i` while both strobes are steady.
- R7: In load mode with the feedback wiring (`par_i[i]` = `q_o[i+1]`, `par_i[WIDTH-1]` = new serial bit), each load strobe moves the data one place from the top bit toward bit 0.
- R8: With both strobes driven from one signal, a falling edge shifts when `mode_load_i` is 0 and loads when `mode_load_i` is 1.
- R9: A strobe level needs to last only one `clk` period, so strobe edges at half the system clock rate are each acted on once. `q_o` changes at the third rising `clk` edge after a strobe input falls, and not earlier. This assumes `SYNC_STAGES` = 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_sh_i | input | 1 | Shift strobe, asynchronous, acts on falling edge |
| strobe_ld_i | input | 1 | Load strobe, asynchronous, acts on falling edge |
| mode_load_i | input | 1 | 1 selects parallel load, 0 selects shift |
| ser_i | input | 1 | Serial data entering bit 0 |
| par_i | input | WIDTH | Parallel load data |
| q_o | output | WIDTH | Register contents |

## Verification
The bench builds the block with its default `WIDTH` of 4 and `SYNC_STAGES` of 2.

At that width every register value is reachable. The bench does the following:
- It loads each of the 16 values and follows each with four shifts, so every bit passes through every stage.
- It runs the external feedback for shifting toward bit 0 over several values.
- It checks the three-edge latency.
- It toggles a strobe every system clock cycle, so the fastest supported strobe rate is exercised against a reference model computed in the bench.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_SHIFT = 2'd1,
      OP_LOAD  = 2'd2
   } shreg_op_e;

endpackage

// File: rtl/strobe_fall_detect.sv
module strobe_fall_detect #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic strobe_i,
   output logic fall_o
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("strobe_fall_detect: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              hist_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= '0;
         hist_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], strobe_i};
         hist_q <= sync_q[LAST];
      end
   end

   assign fall_o = hist_q & ~sync_q[LAST];

   AST_FALL_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      fall_o |=> !fall_o); // R9

endmodule

// File: rtl/shreg_core.sv
module shreg_core
   import shreg_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  shreg_op_e        op_i,
   input  logic             ser_i,
   input  logic [WIDTH-1:0] par_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("shreg_core: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] shift_src;
   logic [WIDTH-1:0] nxt;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_entry
         assign shift_src[i] = ser_i;
      end else begin : g_chain
         assign shift_src[i] = q_o[i-1];
      end

      always_comb begin
         unique case (op_i)
            OP_SHIFT: nxt[i] = shift_src[i];
            OP_LOAD:  nxt[i] = par_i[i];
            default:  nxt[i] = q_o[i];
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) q_o <= '0;
      else     q_o <= nxt;
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (q_o == '0)); // R1

   AST_LOAD_TAKES_PAR: assert property (@(posedge clk) disable iff (rst)
      (op_i == OP_LOAD) |=> (q_o == $past(par_i))); // R2

   AST_SHIFT_MOVES_UP: assert property (@(posedge clk) disable iff (rst)
      (op_i == OP_SHIFT) |=> (q_o[0] == $past(ser_i)) && (q_o[TOP:1] == $past(q_o[TOP-1:0]))); // R4

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (op_i == OP_HOLD) |=> $stable(q_o)); // R6

endmodule

// File: rtl/dual_strobe_shift_reg.sv
module dual_strobe_shift_reg
   import shreg_pkg::*;
#(
   parameter int WIDTH       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             strobe_sh_i,
   input  logic             strobe_ld_i,
   input  logic             mode_load_i,
   input  logic             ser_i,
   input  logic [WIDTH-1:0] par_i,
   output logic [WIDTH-1:0] q_o
);

   logic      fall_sh;
   logic      fall_ld;
   shreg_op_e op;

   strobe_fall_detect #(.STAGES(SYNC_STAGES)) u_det_sh (
      .clk      (clk),
      .rst      (rst),
      .strobe_i (strobe_sh_i),
      .fall_o   (fall_sh)
   );

   strobe_fall_detect #(.STAGES(SYNC_STAGES)) u_det_ld (
      .clk      (clk),
      .rst      (rst),
      .strobe_i (strobe_ld_i),
      .fall_o   (fall_ld)
   );

   always_comb begin
      op = OP_HOLD;
      if (mode_load_i && fall_ld)       op = OP_LOAD;
      else if (!mode_load_i && fall_sh) op = OP_SHIFT;
   end

   shreg_core #(.WIDTH(WIDTH)) u_core (
      .clk   (clk),
      .rst   (rst),
      .op_i  (op),
      .ser_i (ser_i),
      .par_i (par_i),
      .q_o   (q_o)
   );

   AST_WRONG_STROBE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      ((fall_sh && mode_load_i && !fall_ld) || (fall_ld && !mode_load_i && !fall_sh)) |=> $stable(q_o)); // R6

endmodule

// File: tb/sim_dual_strobe_shift_reg.sv
module sim_dual_strobe_shift_reg;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         strobe_sh = 1'b1;
   logic         strobe_ld = 1'b1;
   logic         mode = 1'b0;
   logic         ser = 1'b0;
   logic [W-1:0] par = '0;
   logic [W-1:0] q;
   logic [W-1:0] model;

   int n_checks = 0;
   int n_fails  = 0;

   always #10 clk = ~clk;

   dual_strobe_shift_reg #(.WIDTH(W), .SYNC_STAGES(2)) u0 (
      .clk         (clk),
      .rst         (rst),
      .strobe_sh_i (strobe_sh),
      .strobe_ld_i (strobe_ld),
      .mode_load_i (mode),
      .ser_i       (ser),
      .par_i       (par),
      .q_o         (q)
   );

   task automatic check(input logic [W-1:0] exp, input string tag);
      n_checks++;
      if (q !== exp) begin
         n_fails++;
         $display("FAIL %s: q=%b expected %b at %0t", tag, q, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_load(input logic [W-1:0] val, input logic sr);
      @(negedge clk);
      mode = 1'b1; par = val; ser = sr; strobe_ld = 1'b0;
      idle(4);
      model = val;
      check(model, "R2/R3 load");
      par = ~val; ser = ~sr; strobe_ld = 1'b1;
      idle(4);
      check(model, "R5 load rise");
   endtask

   task automatic do_shift(input logic sr);
      @(negedge clk);
      mode = 1'b0; ser = sr; strobe_sh = 1'b0;
      idle(4);
      model = {model[W-2:0], sr};
      check(model, "R4 shift");
      ser = ~sr; par = ~par; strobe_sh = 1'b1;
      idle(4);
      check(model, "R5 shift rise");
   endtask

   task automatic shift_left(input logic sr);
      @(negedge clk);
      mode = 1'b1; par = {sr, q[W-1:1]}; strobe_ld = 1'b0;
      idle(4);
      model = {sr, model[W-1:1]};
      check(model, "R7 shift toward bit 0");
      strobe_ld = 1'b1;
      idle(4);
   endtask

   task automatic tied_pulse(input logic m, input logic sr, input logic [W-1:0] val);
      @(negedge clk);
      mode = m; ser = sr; par = val;
      strobe_sh = 1'b0; strobe_ld = 1'b0;
      idle(4);
      model = m ? val : {model[W-2:0], sr};
      check(model, "R8 tied strobes");
      strobe_sh = 1'b1; strobe_ld = 1'b1;
      idle(4);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: expired, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      model = '0;
      idle(3);
      check('0, "R1 reset value");
      rst = 1'b0;
      idle(6);
      check('0, "R1 no false edge after reset");

      // R2 R3 R4 R5 sweep over every value
      for (int v = 0; v < (1 << W); v++) begin
         do_load(W'(v), v[0]);
         for (int k = 0; k < W; k++) do_shift(~v[k]);
      end

      // R6 wrong strobe for the mode, and mode toggling
      do_load(4'b1010, 1'b0);
      @(negedge clk); mode = 1'b1; ser = 1'b1; strobe_sh = 1'b0;
      idle(5);
      check(model, "R6 shift strobe in load mode");
      strobe_sh = 1'b1; idle(4);
      @(negedge clk); mode = 1'b0; par = 4'b0101; strobe_ld = 1'b0;
      idle(5);
      check(model, "R6 load strobe in shift mode");
      strobe_ld = 1'b1; idle(4);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk); mode = ~mode;
      end
      idle(4);
      check(model, "R6 mode toggling");

      // R7 external feedback shifts toward bit 0
      do_load(4'b0001, 1'b0);
      shift_left(1'b1);
      shift_left(1'b0);
      shift_left(1'b1);
      shift_left(1'b1);
      do_load(4'b1000, 1'b1);
      for (int k = 0; k < W; k++) shift_left(1'b0);

      // R8 tied strobes
      tied_pulse(1'b1, 1'b0, 4'b0110);
      tied_pulse(1'b0, 1'b1, 4'b0000);
      tied_pulse(1'b0, 1'b0, 4'b1111);
      tied_pulse(1'b1, 1'b1, 4'b1001);

      // R9 latency of three system edges
      do_load(4'b0000, 1'b0);
      @(negedge clk); mode = 1'b0; ser = 1'b1; strobe_sh = 1'b0;
      idle(2);
      check(model, "R9 no change before third edge");
      idle(1);
      model = {model[W-2:0], 1'b1};
      check(model, "R9 change at third edge");
      idle(2); strobe_sh = 1'b1; idle(4);

      // R9 strobe toggling every system clock
      do_load(4'b0000, 1'b0);
      @(negedge clk); mode = 1'b0; ser = 1'b1;
      for (int k = 0; k < 8; k++) begin
         strobe_sh = ~strobe_sh;
         @(negedge clk);
      end
      idle(5);
      model = 4'b1111;
      check(model, "R9 fast burst ser=1");
      ser = 1'b0;
      for (int k = 0; k < 4; k++) begin
         strobe_sh = ~strobe_sh;
         @(negedge clk);
      end
      idle(5);
      model = 4'b1100;
      check(model, "R9 fast burst ser=0");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule